// File: doc/BRIEF.md
# Prioritized Interrupt Entry and Return Sequencer

This block sits next to a small processor core and controls how interrupts are taken and how handlers return. It watches a set of level-sensitive maskable request lines, one non-maskable request input, the core's status word and its program counter. When it takes a request, it writes the status word and then the program counter to a word-addressed stack that grows downward. It then redirects the core to the handler for that source and clears the interrupt-enable bit in the core's status word.

When the core presents a return instruction, the block reads the two saved words back in reverse order and writes them into the program counter and the status word. The interrupt-enable state that held before the interrupt therefore comes back. Entry and return each take two stack cycles, and `busy` is high during them. Requests that arrive during a sequence are held and looked at again when the sequence has finished, so interrupts can nest.

Top module: `irq_entry_seq`

## Requirements
- R1: A maskable line is taken only while bit IE_BIT (default 7) of `psr_in` is 1; if that bit is 0, no stack write happens however long the lines stay high.
- R2: The non-maskable request is source index 0. It takes precedence over every maskable line and is taken whatever the value of the enable bit.
- R3: Maskable line k is source index k+1. When several lines are active together, the lowest-numbered line is taken.
- R4: The handler address written to `pc_wr_val` is VEC_BASE + 4 × source index.
- R5: Entry is two cycles with `stk_we` and `busy` high. The first cycle writes the captured status word to address SP−1, and the second writes the captured PC to SP−2. The stack pointer starts at SP_INIT and goes down by one for each write.
- R6: In the second entry cycle, `pc_wr` and `psr_wr` are both high, and `psr_wr_val` is the saved status word with its enable bit cleared. No maskable request is taken in the cycle that follows.
- R7: A return starts only when `ret_valid` is high and `ret_word` has bits [31:30]=2'b10, bits [24:19]=6'b111001 and bits [29:25]=0. Any other word causes no stack read and no register write.
- R8: A return is two cycles with `stk_re` and `busy` high. The first cycle reads the PC at SP and drives it on `pc_wr_val`. The second reads the status word at SP+1 and drives it on `psr_wr_val`. The pointer goes up by one for each read.
- R9: A request that arrives while an entry is in progress is held and taken afterwards, which produces a nested entry with its own pair of stack words.
- R10: The non-maskable input is edge-triggered: one rising edge produces exactly one entry, however long the input then stays high.
- R11: During reset, `busy`, `stk_we`, `stk_re`, `pc_wr` and `psr_wr` are all 0, and the stack pointer is set to SP_INIT.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lvl | input | NUM_IRQ | Maskable request lines, level-sensitive |
| nmi_in | input | 1 | Non-maskable request, rising-edge triggered |
| psr_in | input | DW | Core status word, holding the enable bit |
| pc_in | input | AW | Core program counter |
| ret_valid | input | 1 | Strobe qualifying `ret_word` |
| ret_word | input | 32 | Instruction word checked for the return opcode |
| busy | output | 1 | High during push and pop cycles |
| stk_we | output | 1 | Stack write strobe |
| stk_re | output | 1 | Stack read strobe |
| stk_addr | output | SAW | Stack word address |
| stk_wdata | output | DW | Stack write data |
| stk_rdata | input | DW | Stack read data, valid in the same cycle as the read |
| pc_wr | output | 1 | Load strobe for the core PC |
| pc_wr_val | output | AW | New PC value |
| psr_wr | output | 1 | Load strobe for the core status word |
| psr_wr_val | output | DW | New status word value |

## Verification
The checker module runs on every cycle. It checks that each push is followed by the second push at the next lower address, and that each PC pop is followed by the status pop at the next higher address. It also checks that the status word written on entry always has its enable bit clear, that a maskable request is never taken while the enable bit is low or while a non-maskable request is waiting, and that no maskable request is taken in the cycle after an entry. The bench scenarios cover what needs a whole sequence to show: which source wins for a given mix of lines, that the saved words come back into the core after a return, that one long non-maskable pulse produces a single entry, and that a request held during an entry turns into a correctly stacked nested entry.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH_PSR,
    ST_PUSH_PC,
    ST_HOLD,
    ST_POP_PC,
    ST_POP_PSR
  } seq_state_e;

  localparam logic [1:0] FMT_ARITH = 2'b10;
  localparam logic [5:0] OP3_RET   = 6'b111001;

  // Return-from-trap recognition: arithmetic format, matching op3, rd all zero
  function automatic logic is_ret_word(input logic [31:0] w);
    return (w[31:30] == FMT_ARITH) && (w[24:19] == OP3_RET) && (w[29:25] == 5'd0);
  endfunction

endpackage

// File: rtl/irq_nmi_edge.sv
module irq_nmi_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_in,
  input  logic take,
  output logic pend
);
  logic nmi_q;
  logic rise;

  assign rise = nmi_in & ~nmi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nmi_q <= 1'b0;
      pend  <= 1'b0;
    end else begin
      nmi_q <= nmi_in;
      pend  <= (pend & ~take) | rise;
    end
  end
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel #(
  parameter int N_SRC = 5,
  parameter int IDX_W = 3
) (
  input  logic [N_SRC-1:0] req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  logic [N_SRC-1:0] grant;

  assign grant[0] = req[0];

  genvar g;
  generate
    for (g = 1; g < N_SRC; g++) begin : g_grant
      assign grant[g] = req[g] & ~(|req[g-1:0]);
    end
  endgenerate

  assign any = |req;

  always_comb begin
    idx = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (grant[i]) idx = idx | IDX_W'(i);
    end
  end
endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
  import irq_seq_pkg::*;
#(
  parameter int            DW       = 32,
  parameter int            AW       = 32,
  parameter int            SAW      = 8,
  parameter int            IDX_W    = 3,
  parameter int            IE_BIT   = 7,
  parameter logic [SAW-1:0] SP_INIT = 8'h80,
  parameter logic [AW-1:0] VEC_BASE = 32'h0000_0400
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             any_req,
  input  logic [IDX_W-1:0] sel_idx,
  input  logic             ret_hit,
  input  logic [DW-1:0]    psr_in,
  input  logic [AW-1:0]    pc_in,
  input  logic [DW-1:0]    stk_rdata,
  output logic             accept,
  output logic             ret_go,
  output logic             can_accept,
  output logic             mask_open,
  output logic             busy,
  output logic             stk_we,
  output logic             stk_re,
  output logic [SAW-1:0]   stk_addr,
  output logic [DW-1:0]    stk_wdata,
  output logic             pc_wr,
  output logic [AW-1:0]    pc_wr_val,
  output logic             psr_wr,
  output logic [DW-1:0]    psr_wr_val
);
  localparam logic [SAW-1:0] SP_ONE = SAW'(1);

  seq_state_e       state, state_n;
  logic [SAW-1:0]   sp;
  logic [DW-1:0]    psr_cap;
  logic [AW-1:0]    pc_cap;
  logic [IDX_W-1:0] idx_cap;

  function automatic logic [AW-1:0] vec_addr(input logic [IDX_W-1:0] i);
    return VEC_BASE + (AW'(i) << 2);
  endfunction

  function automatic logic [DW-1:0] drop_ie(input logic [DW-1:0] p);
    logic [DW-1:0] r;
    r         = p;
    r[IE_BIT] = 1'b0;
    return r;
  endfunction

  assign can_accept = (state == ST_IDLE) || (state == ST_HOLD);
  assign mask_open  = (state == ST_IDLE);
  assign ret_go     = can_accept & ret_hit;
  assign accept     = can_accept & any_req & ~ret_hit;

  always_comb begin
    state_n = state;
    unique case (state)
      ST_IDLE, ST_HOLD: begin
        if (ret_go)      state_n = ST_POP_PC;
        else if (accept) state_n = ST_PUSH_PSR;
        else             state_n = ST_IDLE;
      end
      ST_PUSH_PSR: state_n = ST_PUSH_PC;
      ST_PUSH_PC:  state_n = ST_HOLD;
      ST_POP_PC:   state_n = ST_POP_PSR;
      ST_POP_PSR:  state_n = ST_IDLE;
      default:     state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      sp      <= SP_INIT;
      psr_cap <= '0;
      pc_cap  <= '0;
      idx_cap <= '0;
    end else begin
      state <= state_n;
      if (accept) begin
        psr_cap <= psr_in;
        pc_cap  <= pc_in;
        idx_cap <= sel_idx;
      end
      if (stk_we) sp <= sp - SP_ONE;
      else if (stk_re) sp <= sp + SP_ONE;
    end
  end

  always_comb begin
    busy       = 1'b0;
    stk_we     = 1'b0;
    stk_re     = 1'b0;
    stk_addr   = sp;
    stk_wdata  = '0;
    pc_wr      = 1'b0;
    pc_wr_val  = '0;
    psr_wr     = 1'b0;
    psr_wr_val = '0;
    unique case (state)
      ST_PUSH_PSR: begin
        busy      = 1'b1;
        stk_we    = 1'b1;
        stk_addr  = sp - SP_ONE;
        stk_wdata = psr_cap;
      end
      ST_PUSH_PC: begin
        busy       = 1'b1;
        stk_we     = 1'b1;
        stk_addr   = sp - SP_ONE;
        stk_wdata  = DW'(pc_cap);
        pc_wr      = 1'b1;
        pc_wr_val  = vec_addr(idx_cap);
        psr_wr     = 1'b1;
        psr_wr_val = drop_ie(psr_cap);
      end
      ST_POP_PC: begin
        busy      = 1'b1;
        stk_re    = 1'b1;
        pc_wr     = 1'b1;
        pc_wr_val = AW'(stk_rdata);
      end
      ST_POP_PSR: begin
        busy       = 1'b1;
        stk_re     = 1'b1;
        psr_wr     = 1'b1;
        psr_wr_val = stk_rdata;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_seq_pkg::*;
#(
  parameter int             NUM_IRQ  = 4,
  parameter int             DW       = 32,
  parameter int             AW       = 32,
  parameter int             SAW      = 8,
  parameter int             IE_BIT   = 7,
  parameter logic [SAW-1:0] SP_INIT  = 8'h80,
  parameter logic [AW-1:0]  VEC_BASE = 32'h0000_0400
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_lvl,
  input  logic               nmi_in,
  input  logic [DW-1:0]      psr_in,
  input  logic [AW-1:0]      pc_in,
  input  logic               ret_valid,
  input  logic [31:0]        ret_word,
  output logic               busy,
  output logic               stk_we,
  output logic               stk_re,
  output logic [SAW-1:0]     stk_addr,
  output logic [DW-1:0]      stk_wdata,
  input  logic [DW-1:0]      stk_rdata,
  output logic               pc_wr,
  output logic [AW-1:0]      pc_wr_val,
  output logic               psr_wr,
  output logic [DW-1:0]      psr_wr_val
);
  localparam int N_SRC = NUM_IRQ + 1;
  localparam int IDX_W = $clog2(N_SRC);

  logic             nmi_pend;
  logic             can_accept, mask_open;
  logic             any_req, accept, ret_go, ret_hit;
  logic [IDX_W-1:0] sel_idx;
  logic [N_SRC-1:0] req_vec;
  logic             mask_gate;
  logic             take_nmi, take_mask;
  logic             unused_ret_bits;

  assign unused_ret_bits = ^{ret_word[18:0], ret_go};

  assign mask_gate = mask_open & psr_in[IE_BIT];
  assign req_vec   = {irq_lvl & {NUM_IRQ{mask_gate}}, nmi_pend & can_accept};
  assign ret_hit   = ret_valid & is_ret_word(ret_word);
  assign take_nmi  = accept & (sel_idx == '0);
  assign take_mask = accept & (sel_idx != '0);

  irq_nmi_edge u_nmi (
    .clk    (clk),
    .rst_n  (rst_n),
    .nmi_in (nmi_in),
    .take   (take_nmi),
    .pend   (nmi_pend)
  );

  irq_prio_sel #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_prio (
    .req (req_vec),
    .any (any_req),
    .idx (sel_idx)
  );

  irq_seq_fsm #(
    .DW(DW), .AW(AW), .SAW(SAW), .IDX_W(IDX_W), .IE_BIT(IE_BIT),
    .SP_INIT(SP_INIT), .VEC_BASE(VEC_BASE)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .any_req    (any_req),
    .sel_idx    (sel_idx),
    .ret_hit    (ret_hit),
    .psr_in     (psr_in),
    .pc_in      (pc_in),
    .stk_rdata  (stk_rdata),
    .accept     (accept),
    .ret_go     (ret_go),
    .can_accept (can_accept),
    .mask_open  (mask_open),
    .busy       (busy),
    .stk_we     (stk_we),
    .stk_re     (stk_re),
    .stk_addr   (stk_addr),
    .stk_wdata  (stk_wdata),
    .pc_wr      (pc_wr),
    .pc_wr_val  (pc_wr_val),
    .psr_wr     (psr_wr),
    .psr_wr_val (psr_wr_val)
  );
endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk #(
  parameter int DW     = 32,
  parameter int SAW    = 8,
  parameter int IE_BIT = 7
) (
  input logic           clk,
  input logic           rst_n,
  input logic [DW-1:0]  psr_in,
  input logic           busy,
  input logic           stk_we,
  input logic           stk_re,
  input logic [SAW-1:0] stk_addr,
  input logic           pc_wr,
  input logic           psr_wr,
  input logic [DW-1:0]  psr_wr_val,
  input logic           take_mask,
  input logic           nmi_pend
);
  // R1: maskable acceptance needs the enable bit
  a_r1_mask_needs_ie: assert property (@(posedge clk) disable iff (!rst_n)
    take_mask |-> psr_in[IE_BIT]);

  // R2: a waiting non-maskable request blocks maskable acceptance
  a_r2_nmi_first: assert property (@(posedge clk) disable iff (!rst_n)
    take_mask |-> !nmi_pend);

  // R5: first push is followed by the second push one word lower
  a_r5_push_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_we && !pc_wr) |=> (stk_we && pc_wr && stk_addr == $past(stk_addr) - SAW'(1)));

  // R5, R8: stack traffic only while busy, never both directions
  a_r5_busy_cover: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_we || stk_re) |-> (busy && !(stk_we && stk_re)));

  // R6: status written on entry has enable cleared
  a_r6_ie_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_we && psr_wr) |-> !psr_wr_val[IE_BIT]);

  // R6: no maskable acceptance right after entry
  a_r6_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_we && pc_wr) |=> !take_mask);

  // R8: PC pop is followed by status pop one word higher
  a_r8_pop_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_re && pc_wr) |=> (stk_re && psr_wr && stk_addr == $past(stk_addr) + SAW'(1)));
endmodule

bind irq_entry_seq irq_entry_seq_chk #(.DW(DW), .SAW(SAW), .IE_BIT(IE_BIT)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .psr_in     (psr_in),
  .busy       (busy),
  .stk_we     (stk_we),
  .stk_re     (stk_re),
  .stk_addr   (stk_addr),
  .pc_wr      (pc_wr),
  .psr_wr     (psr_wr),
  .psr_wr_val (psr_wr_val),
  .take_mask  (take_mask),
  .nmi_pend   (nmi_pend)
);

// File: tb/irq_entry_seq_tb_top.sv
module irq_entry_seq_tb_top;
  localparam int          NI   = 4;
  localparam logic [7:0]  SPI  = 8'h80;
  localparam logic [31:0] VB   = 32'h0000_0400;
  localparam int          IEB  = 7;
  localparam logic [31:0] IEM  = 32'h1 << IEB;
  localparam logic [31:0] RETT = 32'h81C8_0000; // [31:30]=10, rd=0, op3=111001

  // {exp_idx[10:8], ie[5], nmi[4], irq[3:0]}
  localparam logic [11:0] TBL [8] = '{
    12'h121, 12'h428, 12'h226, 12'h12F, 12'h034, 12'h01F, 12'h22A, 12'h010
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NI-1:0] irq_lvl = '0;
  logic nmi_in = 1'b0;
  logic ret_valid = 1'b0;
  logic [31:0] ret_word = '0;
  logic busy, stk_we, stk_re, pc_wr, psr_wr;
  logic [7:0] stk_addr;
  logic [31:0] stk_wdata, stk_rdata, pc_wr_val, psr_wr_val;

  logic [31:0] core_psr = '0, core_pc = '0;
  logic set_req = 1'b0;
  logic [31:0] set_psr = '0, set_pc = '0;
  logic [31:0] stk_mem [256];

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  assign stk_rdata = stk_mem[stk_addr];

  always @(posedge clk) begin
    if (stk_we) stk_mem[stk_addr] <= stk_wdata;
    if (psr_wr) core_psr <= psr_wr_val;
    else if (set_req) core_psr <= set_psr;
    if (pc_wr) core_pc <= pc_wr_val;
    else if (set_req) core_pc <= set_pc;
  end

  irq_entry_seq dut_i (
    .clk(clk), .rst_n(rst_n), .irq_lvl(irq_lvl), .nmi_in(nmi_in),
    .psr_in(core_psr), .pc_in(core_pc), .ret_valid(ret_valid), .ret_word(ret_word),
    .busy(busy), .stk_we(stk_we), .stk_re(stk_re), .stk_addr(stk_addr),
    .stk_wdata(stk_wdata), .stk_rdata(stk_rdata), .pc_wr(pc_wr), .pc_wr_val(pc_wr_val),
    .psr_wr(psr_wr), .psr_wr_val(psr_wr_val)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_core(input logic [31:0] p, input logic [31:0] c);
    @(negedge clk);
    set_req = 1'b1; set_psr = p; set_pc = c;
    @(negedge clk);
    set_req = 1'b0;
  endtask

  task automatic entry_chk(input int idx, input logic [31:0] ep, input logic [31:0] ec,
                           input logic [7:0] top, input string tag);
    bit found = 1'b0;
    for (int k = 0; k < 40 && !found; k++) begin
      @(negedge clk);
      found = stk_we;
    end
    chk(found, {tag, " entry started"}, 32'(found), 32'h1);
    chk(busy && !pc_wr && stk_addr == top - 8'd1 && stk_wdata == ep,
        "R5 first push status", stk_wdata, ep);
    @(negedge clk);
    chk(stk_we && busy && stk_addr == top - 8'd2 && stk_wdata == ec,
        "R5 second push pc", stk_wdata, ec);
    chk(pc_wr && pc_wr_val == VB + 32'(idx) * 4, {tag, " R4 vector"}, pc_wr_val, VB + 32'(idx) * 4);
    chk(psr_wr && psr_wr_val == (ep & ~IEM), "R6 enable cleared", psr_wr_val, ep & ~IEM);
  endtask

  task automatic ret_chk(input logic [31:0] ep, input logic [31:0] ec, input logic [7:0] top);
    @(negedge clk);
    ret_valid = 1'b1; ret_word = RETT;
    @(negedge clk);
    ret_valid = 1'b0; ret_word = '0;
    chk(stk_re && busy && stk_addr == top - 8'd2 && pc_wr && pc_wr_val == ec,
        "R8 pop pc", pc_wr_val, ec);
    @(negedge clk);
    chk(stk_re && stk_addr == top - 8'd1 && psr_wr && psr_wr_val == ep,
        "R8 pop status", psr_wr_val, ep);
    @(negedge clk);
    chk(!busy && core_psr == ep && core_pc == ec, "R8 core restored", core_psr, ep);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] p, c, p2, vec3;
    int cnt;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!busy && !stk_we && !stk_re && !pc_wr && !psr_wr, "R11 reset outputs",
        {27'd0, busy, stk_we, stk_re, pc_wr, psr_wr}, 32'h0);
    rst_n = 1'b1;

    // vector table walk
    for (int r = 0; r < 8; r++) begin
      logic [11:0] e;
      e = TBL[r];
      p = 32'h0000_5A00 | (e[5] ? IEM : 32'h0) | 32'(r);
      c = 32'h2000_0000 + 32'(r) * 32'h40;
      set_core(p, c);
      @(negedge clk);
      nmi_in = e[4];
      @(negedge clk);
      nmi_in = 1'b0;
      irq_lvl = e[3:0];
      entry_chk(int'(e[10:8]), p, c, SPI, e[4] ? "R2 nmi priority" : "R3 line priority");
      irq_lvl = '0;
      ret_chk(p, c, SPI);
    end

    // R1: masked lines ignored
    set_core(32'h0000_0011, 32'h3000_0000);
    irq_lvl = 4'hF;
    cnt = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (stk_we) cnt++;
    end
    chk(cnt == 0, "R1 masked no entry", 32'(cnt), 32'h0);
    irq_lvl = '0;

    // R7: near-miss return words ignored
    for (int k = 0; k < 3; k++) begin
      logic [31:0] w;
      w = (k == 0) ? (RETT | 32'h0200_0000) : (k == 1) ? (RETT ^ 32'h0008_0000) : (RETT | 32'h4000_0000);
      @(negedge clk);
      ret_valid = 1'b1; ret_word = w;
      @(negedge clk);
      ret_valid = 1'b0; ret_word = '0;
      cnt = 0;
      for (int j = 0; j < 4; j++) begin
        if (stk_re || pc_wr || psr_wr) cnt++;
        @(negedge clk);
      end
      chk(cnt == 0 && core_pc == 32'h3000_0000, "R7 bad return word ignored", 32'(cnt), 32'h0);
    end

    // R10: held non-maskable input gives one entry
    p = 32'h0000_0C00 | IEM;
    c = 32'h4000_0000;
    set_core(p, c);
    nmi_in = 1'b1;
    cnt = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (stk_we) cnt++;
    end
    chk(cnt == 2, "R10 single entry for held nmi", 32'(cnt), 32'h2);
    chk(core_pc == VB, "R10 nmi vector", core_pc, VB);
    nmi_in = 1'b0;
    ret_chk(p, c, SPI);

    // R9: request during entry stays pending, nests
    p = 32'h0000_0300 | IEM;
    c = 32'h5000_0000;
    vec3 = VB + 32'd12;
    set_core(p, c);
    @(negedge clk);
    irq_lvl = 4'b0100;
    entry_chk(3, p, c, SPI, "R3 line 2");
    chk(busy, "R9 nmi raised while busy", 32'(busy), 32'h1);
    nmi_in = 1'b1;
    irq_lvl = '0;
    @(negedge clk);
    nmi_in = 1'b0;
    p2 = p & ~IEM;
    entry_chk(0, p2, vec3, SPI - 8'd2, "R9 pending nmi nested");
    ret_chk(p2, vec3, SPI - 8'd2);
    ret_chk(p, c, SPI);

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule